// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Event Interrupts

This block is an eight-pin general-purpose I/O port. It holds a direction mask, an output value and one small control register per pin, and it samples the external pin levels. Software reaches the same state through two register windows. The compact window has four registers. The full window adds atomic set, clear and toggle registers and the eight per-pin control registers. A write through either window lands in the same storage, so both windows always read back the same values.

Each pin's control register picks an input event: both edges, rising edge, falling edge, or low level. The event is judged against the effective input value. For a pin driven as an output, that value is the pin's own output bit, so toggling an output can raise its flag. Event flags are cleared by writing a one to them, through either window. The port has one interrupt line, and it stays asserted while any flag is set. No separate enable register exists: a pin takes part only when its sense mode is active.

Register access uses one single-cycle write port. Reads come from a combinational read port. Each port has a window-select bit.

Top module: `gpio_octet_port`

## Requirements
- R1: After reset, direction, output, all pin control registers and all flags are zero, and `irq` is low.
- R2: Direction is at full offset 0x00 and compact offset 0x00. Output is at full offset 0x04 and compact offset 0x01. A write through either window appears on `pin_dir`/`pin_out` and in reads from both windows one cycle later.
- R3: The full window applies the written mask to direction and to output as follows. Direction: OR at 0x01, AND-NOT at 0x02, XOR at 0x03. Output: OR at 0x05, AND-NOT at 0x06, XOR at 0x07.
- R4: IN is at full offset 0x08 and compact offset 0x02. For output pins it returns the output bit. For input pins it returns `pin_in` delayed by two clock edges. Writes to IN have no effect.
- R5: Pin i's control register is at full offset 0x10+i. Bits [2:0] select the sense mode and bit 3 drives `pin_pullup[i]`. Bits [7:4] read as zero.
- R6: Mode 1 (both edges), mode 2 (rising) and mode 3 (falling) set the pin's flag on the clock edge after the matching change in the IN value. This includes changes caused by the pin's own output. Modes 0, 4, 6 and 7 never set a flag.
- R7: Mode 5 (low level) sets the pin's flag on every clock edge at which the pin's IN value is low.
- R8: Flags read at full offset 0x09 and compact offset 0x03. Writing ones there clears the matching flags, and zero bits leave flags unchanged. If an event occurs in the same cycle as a clear of the same flag, the flag stays set.
- R9: `irq` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_full | input | 1 | Write window select: 1 full, 0 compact |
| wr_addr | input | 5 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_full | input | 1 | Read window select: 1 full, 0 compact |
| rd_addr | input | 5 | Read register offset |
| rd_data | output | 8 | Read data, combinational; unmapped and write-only offsets read zero |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_dir | output | 8 | Direction, 1 = output |
| pin_out | output | 8 | Output value |
| pin_pullup | output | 8 | Per-pin pull-up enable |
| irq | output | 1 | Port interrupt |

## Verification
The assertions assume that the write inputs are never unknown and that each write strobe stands for exactly one cycle of intent. Offsets outside the map are expected to be harmless, not absent. The bench drives every input at the falling edge, so the values are stable at the sampling edge. It mixes in writes to unmapped and read-only offsets, and it changes `pin_in` only occasionally, so that edge, level and clear events overlap often without any input ever being unknown.

// File: rtl/gpio_octet_port.sv
module gpio_octet_port #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_full,
  input  logic [4:0]      wr_addr,
  input  logic [PINS-1:0] wr_data,
  input  logic            rd_full,
  input  logic [4:0]      rd_addr,
  output logic [PINS-1:0] rd_data,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_dir,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_pullup,
  output logic            irq
);
  localparam logic [4:0] F_DIR = 5'h00, F_DSET = 5'h01, F_DCLR = 5'h02, F_DTGL = 5'h03;
  localparam logic [4:0] F_OUT = 5'h04, F_OSET = 5'h05, F_OCLR = 5'h06, F_OTGL = 5'h07;
  localparam logic [4:0] F_IN = 5'h08, F_FLG = 5'h09, F_CTL = 5'h10;
  localparam logic [4:0] C_DIR = 5'h00, C_OUT = 5'h01, C_IN = 5'h02, C_FLG = 5'h03;

  logic [PINS-1:0] dir_q, out_q, flg_q, sync1_q, sync2_q, prev_q;
  logic [PINS-1:0] dir_n, out_n, clr, evt, in_val;
  logic [3:0]      ctl_q [PINS];

  wire w_full = wr_en & wr_full;
  wire w_cmp  = wr_en & ~wr_full;

  assign in_val  = (dir_q & out_q) | (~dir_q & sync2_q);
  assign pin_dir = dir_q;
  assign pin_out = out_q;
  assign irq     = |flg_q;

  always_comb begin
    dir_n = dir_q;
    out_n = out_q;
    clr   = '0;
    if (w_full) begin
      case (wr_addr)
        F_DIR:   dir_n = wr_data;
        F_DSET:  dir_n = dir_q | wr_data;
        F_DCLR:  dir_n = dir_q & ~wr_data;
        F_DTGL:  dir_n = dir_q ^ wr_data;
        F_OUT:   out_n = wr_data;
        F_OSET:  out_n = out_q | wr_data;
        F_OCLR:  out_n = out_q & ~wr_data;
        F_OTGL:  out_n = out_q ^ wr_data;
        F_FLG:   clr   = wr_data;
        default: ;
      endcase
    end else if (w_cmp) begin
      case (wr_addr)
        C_DIR:   dir_n = wr_data;
        C_OUT:   out_n = wr_data;
        C_FLG:   clr   = wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[i] <= '0;
      else if (w_full && wr_addr == F_CTL + 5'(i)) ctl_q[i] <= wr_data[3:0];
    end
    assign pin_pullup[i] = ctl_q[i][3];
    always_comb begin
      case (ctl_q[i][2:0])
        3'd1:    evt[i] = in_val[i] ^ prev_q[i];
        3'd2:    evt[i] = in_val[i] & ~prev_q[i];
        3'd3:    evt[i] = ~in_val[i] & prev_q[i];
        3'd5:    evt[i] = ~in_val[i];
        default: evt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      flg_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      dir_q   <= dir_n;
      out_q   <= out_n;
      flg_q   <= (flg_q & ~clr) | evt;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= in_val;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_full) begin
      case (rd_addr)
        F_DIR:   rd_data = dir_q;
        F_OUT:   rd_data = out_q;
        F_IN:    rd_data = in_val;
        F_FLG:   rd_data = flg_q;
        default:
          if (rd_addr >= F_CTL && rd_addr < F_CTL + 5'(PINS))
            rd_data = PINS'(ctl_q[rd_addr - F_CTL]);
      endcase
    end else begin
      case (rd_addr)
        C_DIR:   rd_data = dir_q;
        C_OUT:   rd_data = out_q;
        C_IN:    rd_data = in_val;
        C_FLG:   rd_data = flg_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_octet_port_chk.sv
module gpio_octet_port_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_full,
  input logic [4:0]      wr_addr,
  input logic [PINS-1:0] wr_data,
  input logic [PINS-1:0] pin_dir,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] flg_q,
  input logic [3:0]      ctl_q [PINS],
  input logic            irq
);
  wire clr_wr = wr_en && ((wr_full && wr_addr == 5'h09) || (!wr_full && wr_addr == 5'h03));

  // R2
  cmp_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_full && wr_addr == 5'h00) |=> pin_dir == $past(wr_data));

  // R3
  out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full && wr_addr == 5'h07) |=> pin_out == ($past(pin_out) ^ $past(wr_data)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_wr));

  for (genvar i = 0; i < PINS; i++) begin : g_m
    // R6
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl_q[i][2:0]) inside {3'd0, 3'd4, 3'd6, 3'd7} && !$past(flg_q[i])) |-> !flg_q[i]);
  end
endmodule

bind gpio_octet_port gpio_octet_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full), .wr_addr(wr_addr),
  .wr_data(wr_data), .pin_dir(pin_dir), .pin_out(pin_out), .flg_q(flg_q),
  .ctl_q(ctl_q), .irq(irq)
);

// File: tb/sim_gpio_octet_port.sv
module sim_gpio_octet_port;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_full = 0, rd_full = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, pin_in = 0;
  logic [7:0] rd_data, pin_dir, pin_out, pin_pullup;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_octet_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_full(rd_full), .rd_addr(rd_addr),
    .rd_data(rd_data), .pin_in(pin_in), .pin_dir(pin_dir), .pin_out(pin_out),
    .pin_pullup(pin_pullup), .irq(irq));

  logic [7:0] m_dir = 0, m_out = 0, m_flg = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic [3:0] m_ctl [8] = '{default: 4'h0};

  function automatic logic [7:0] m_in();
    return (m_dir & m_out) | (~m_dir & m_s2);
  endfunction

  function automatic logic [7:0] m_read(input logic full, input logic [4:0] a);
    if (full) begin
      if (a == 5'h00) return m_dir;
      if (a == 5'h04) return m_out;
      if (a == 5'h08) return m_in();
      if (a == 5'h09) return m_flg;
      if (a >= 5'h10 && a <= 5'h17) return {4'h0, m_ctl[a - 5'h10]};
      return 8'h00;
    end
    case (a)
      5'h00: return m_dir;
      5'h01: return m_out;
      5'h02: return m_in();
      5'h03: return m_flg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_update();
    logic [7:0] cur, ev, clr, nd, no;
    cur = m_in(); ev = 0; clr = 0; nd = m_dir; no = m_out;
    for (int i = 0; i < 8; i++) begin
      case (m_ctl[i][2:0])
        3'd1: ev[i] = cur[i] != m_prev[i];
        3'd2: ev[i] = cur[i] && !m_prev[i];
        3'd3: ev[i] = !cur[i] && m_prev[i];
        3'd5: ev[i] = !cur[i];
        default: ev[i] = 0;
      endcase
    end
    if (wr_en && wr_full) begin
      case (wr_addr)
        5'h00: nd = wr_data;
        5'h01: nd = m_dir | wr_data;
        5'h02: nd = m_dir & ~wr_data;
        5'h03: nd = m_dir ^ wr_data;
        5'h04: no = wr_data;
        5'h05: no = m_out | wr_data;
        5'h06: no = m_out & ~wr_data;
        5'h07: no = m_out ^ wr_data;
        5'h09: clr = wr_data;
        default: if (wr_addr >= 5'h10 && wr_addr <= 5'h17) m_ctl[wr_addr - 5'h10] = wr_data[3:0];
      endcase
    end else if (wr_en) begin
      case (wr_addr)
        5'h00: nd = wr_data;
        5'h01: no = wr_data;
        5'h03: clr = wr_data;
        default: ;
      endcase
    end
    m_flg = (m_flg & ~clr) | ev;
    m_dir = nd; m_out = no; m_prev = cur;
    m_s2 = m_s1; m_s1 = pin_in;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic full, input logic [4:0] a, input logic [7:0] d);
    wr_en = we; wr_full = full; wr_addr = a; wr_data = d;
    @(posedge clk); #1 m_update();
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic full, input logic [4:0] a, input logic [7:0] lit);
    rd_full = full; rd_addr = a; #1;
    chk(tag, rd_data, lit);
    chk({tag, " model"}, rd_data, m_read(full, a));
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_61f0);
    @(negedge clk); @(negedge clk); rst_n = 1;
    // R1 reset state
    rd("R1 dir", 1, 5'h00, 8'h00);
    rd("R1 flags", 0, 5'h03, 8'h00);
    rd("R1 ctl3", 1, 5'h13, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R2 cross-window coherence
    step(1, 0, 5'h00, 8'hF0);
    rd("R2 dir via full", 1, 5'h00, 8'hF0);
    step(1, 1, 5'h04, 8'h3C);
    rd("R2 out via compact", 0, 5'h01, 8'h3C);
    chk("R2 pin_out", pin_out, 8'h3C);
    // R3 set/clear/toggle
    step(1, 1, 5'h05, 8'h01); rd("R3 outset", 1, 5'h04, 8'h3D);
    step(1, 1, 5'h06, 8'h0C); rd("R3 outclr", 1, 5'h04, 8'h31);
    step(1, 1, 5'h07, 8'hFF); rd("R3 outtgl", 1, 5'h04, 8'hCE);
    step(1, 1, 5'h01, 8'h0F); rd("R3 dirset", 1, 5'h00, 8'hFF);
    step(1, 1, 5'h02, 8'hF0); rd("R3 dirclr", 1, 5'h00, 8'h0F);
    step(1, 1, 5'h03, 8'h03); rd("R3 dirtgl", 1, 5'h00, 8'h0C);
    // R4 IN mix and ignored write
    pin_in = 8'hA5;
    step(1, 1, 5'h08, 8'hFF);
    rd("R4 in after one edge", 1, 5'h08, 8'h0C);
    step(0, 0, 0, 0);
    rd("R4 in after two edges", 0, 5'h02, 8'hA1 | 8'h0C);
    // R5 control and pull-up
    step(1, 1, 5'h12, 8'hFA);
    rd("R5 ctl2 readback", 1, 5'h12, 8'h0A);
    chk("R5 pullup", pin_pullup, 8'h04);
    // R6 rising on input pin 1 (dir bit1 = 0)
    step(1, 1, 5'h11, 8'h02);
    pin_in[1] = 1'b1;
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    rd("R6 no flag yet", 1, 5'h09, 8'h00);
    step(0, 0, 0, 0);
    rd("R6 rising flag", 1, 5'h09, 8'h02);
    chk("R9 irq high", {7'b0, irq}, 8'h01);
    // R8 clear via compact
    step(1, 0, 5'h03, 8'h02);
    rd("R8 cleared", 0, 5'h03, 8'h00);
    chk("R9 irq low", {7'b0, irq}, 8'h00);
    // R6 output-driven event: pin 3 is output, both edges
    step(1, 1, 5'h13, 8'h01);
    step(1, 1, 5'h07, 8'h08);
    step(0, 0, 0, 0);
    rd("R6 output toggle flag", 1, 5'h09, 8'h08);
    // R6 mode 4 silent
    step(1, 1, 5'h09, 8'hFF);
    step(1, 1, 5'h13, 8'h04);
    step(1, 1, 5'h07, 8'h08);
    step(0, 0, 0, 0);
    rd("R6 mode4 silent", 1, 5'h09, 8'h00);
    // R7 low level on pin 4 (input, pin_in bit4 = 0); event beats clear
    step(1, 1, 5'h14, 8'h05);
    step(0, 0, 0, 0);
    rd("R7 low flag", 1, 5'h09, 8'h10);
    step(1, 1, 5'h09, 8'h10);
    rd("R8 event wins", 1, 5'h09, 8'h10);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic f;
      logic [4:0] a;
      f = $urandom_range(0, 1);
      a = f ? (($urandom_range(0, 3) == 0) ? 5'(5'h10 + $urandom_range(0, 8)) : 5'($urandom_range(0, 10)))
            : 5'($urandom_range(0, 4));
      if ($urandom_range(0, 5) == 0) pin_in = pin_in ^ (8'h1 << $urandom_range(0, 7));
      step($urandom_range(0, 2) != 0, f, a, 8'($urandom));
      rd_full = $urandom_range(0, 1);
      rd_addr = rd_full ? 5'($urandom_range(0, 23)) : 5'($urandom_range(0, 4));
      #1;
      chk("R4/R5/R8 random read", rd_data, m_read(rd_full, rd_addr));
      chk("R2/R3 random pins", pin_dir ^ pin_out, m_dir ^ m_out);
      chk("R9 random irq", {7'b0, irq}, {7'b0, |m_flg});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule